// File: doc/BRIEF.md
# OSD Vertical Line-Position Comparator

This block produces the vertical timing for an on-screen display overlay. It counts horizontal sync pulses from the start of each field. Each count unit is one or two HSYNC periods, chosen by a mode bit. When the unit count reaches the programmed vertical start of one of two character blocks, it emits a one-clock start strobe for that block. It also drives a window-active level that is high from a programmed top border up to a programmed bottom border.

Each position is an 8-bit register value plus a separate extension bit that adds 256 units, so positions span 0 to 511. The top border shares the extension bit of block 1 and the bottom border shares the extension bit of block 2. A zero position with its extension bit clear is not a legal setting. The block flags such a setting and never strobes for it.

HSYNC and VSYNC come in asynchronous and are synchronised to `clk` before edge detection. Configuration is loaded through a plain register write port and can be read back. The block has no data stream, so it has no valid/ready handshake. A write takes effect on the next clock, and no back-pressure is possible.

Top module: `osd_vline_cmp`

## Requirements
- R1: Each of `hsync_in` and `vsync_in` passes through two flip-flop stages before rising-edge detection. A VSYNC rising edge clears the unit count to 0. The count then rises by one per unit and saturates at 511.
- R2: A block's start position is E*256 + n, where n is its start register and E is its extension bit. Its `blk_start` bit pulses for exactly one clock after the count steps onto that position.
- R3: With the line-doubling bit at 0, one unit is one HSYNC rising edge. With it at 1, one unit is two HSYNC rising edges counted from the field start, so a position is reached after twice as many pulses.
- R4: Block 1 (`blk_start[0]`) and block 2 (`blk_start[1]`) compare independently. Both fire in the same clock when their positions are equal.
- R5: The window top is ext1*256 + top and the bottom is ext2*256 + bottom. `win_active` is high on every unit count c with top <= c < bottom, and low otherwise.
- R6: If the top position is not below the bottom position, `win_active` stays low for the whole field.
- R7: A start or top register equal to 0 with its extension bit at 0 sets its `cfg_bad` bit. The bits are: bit0 for start 1, bit1 for start 2, bit2 for top. A start set this way never strobes, and a top set this way never opens the window.
- R8: The register map is:
  - address 0: start 1
  - address 1: start 2
  - address 2: window top
  - address 3: window bottom
  - address 4: control, with bit0 = ext1, bit1 = ext2, bit2 = line doubling

  `rd_data` returns the addressed register, with unused control bits and unused addresses reading 0.
- R9: After reset:
  - `blk_start` and `win_active` are 0.
  - All position and control registers are 0.
  - `cfg_bad` reads 3'b111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hsync_in | input | 1 | Asynchronous horizontal sync, active high |
| vsync_in | input | 1 | Asynchronous vertical sync, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 8 | Read data for `rd_addr` (combinational) |
| blk_start | output | 2 | One-clock start strobe per block |
| win_active | output | 1 | Window-active level |
| cfg_bad | output | 3 | Illegal-zero flags for start 1, start 2 and top |

## Verification
The comparison is tried under several configurations:
- Distinct, ordered start positions show that each block compares against its own register.
- Equal start positions force both strobes into one clock.
- Line-doubling mode halves the unit rate for the same register values, which separates one-pulse units from two-pulse units.
- Extension bits set with small register values put every event beyond line 255, which exposes a lost ninth bit.
- A field with a zero start, and another with an inverted window, show that illegal settings stay silent rather than firing at line 0 or opening a window that wraps.

// File: rtl/osd_vpos_pkg.sv
package osd_vpos_pkg;
  localparam int REG_W  = 8;
  localparam int POS_W  = REG_W + 1;
  localparam int ADDR_W = 3;
  localparam int NBLK   = 2;

  localparam logic [ADDR_W-1:0] A_START1 = 3'd0;
  localparam logic [ADDR_W-1:0] A_START2 = 3'd1;
  localparam logic [ADDR_W-1:0] A_TOP    = 3'd2;
  localparam logic [ADDR_W-1:0] A_BOT    = 3'd3;
  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd4;

  typedef struct packed {
    logic                  dbl;
    logic [NBLK-1:0]       ext;
    logic [REG_W-1:0]      bot;
    logic [REG_W-1:0]      top;
    logic [NBLK-1:0][REG_W-1:0] start;
  } vpos_cfg_t;
endpackage

// File: rtl/osd_sync_rise.sv
module osd_sync_rise #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-1:0], async_in};
  end

  // sh[STAGES-1] is the last synchroniser stage, sh[STAGES] its delayed copy
  assign rise = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/osd_vpos_regs.sv
module osd_vpos_regs
  import osd_vpos_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [REG_W-1:0]  rd_data,
  output vpos_cfg_t         cfg
);
  localparam int CTRL_USED = NBLK + 1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        A_START1: cfg.start[0] <= wr_data;
        A_START2: cfg.start[1] <= wr_data;
        A_TOP:    cfg.top      <= wr_data;
        A_BOT:    cfg.bot      <= wr_data;
        A_CTRL:   {cfg.dbl, cfg.ext} <= wr_data[CTRL_USED-1:0];
        default:  ;
      endcase
    end
  end

  always_comb begin
    case (rd_addr)
      A_START1: rd_data = cfg.start[0];
      A_START2: rd_data = cfg.start[1];
      A_TOP:    rd_data = cfg.top;
      A_BOT:    rd_data = cfg.bot;
      A_CTRL:   rd_data = {{(REG_W-CTRL_USED){1'b0}}, cfg.dbl, cfg.ext};
      default:  rd_data = '0;
    endcase
  end
endmodule

// File: rtl/osd_line_counter.sv
module osd_line_counter #(
  parameter int POS_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hs_rise,
  input  logic             vs_rise,
  input  logic             dbl,
  output logic [POS_W-1:0] cnt,
  output logic             step
);
  localparam logic [POS_W-1:0] CNT_MAX = '1;
  logic half;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      half <= 1'b0;
      step <= 1'b0;
    end else begin
      step <= 1'b0;
      if (vs_rise) begin
        cnt  <= '0;
        half <= 1'b0;
      end else if (hs_rise) begin
        if (dbl && !half) begin
          half <= 1'b1;
        end else begin
          half <= 1'b0;
          if (cnt != CNT_MAX) begin
            cnt  <= cnt + 1'b1;
            step <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/osd_start_cmp.sv
module osd_start_cmp #(
  parameter int REG_W = 8,
  parameter int POS_W = REG_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [POS_W-1:0] cnt,
  input  logic             step,
  input  logic [REG_W-1:0] n,
  input  logic             ext,
  output logic [POS_W-1:0] pos,
  output logic             bad,
  output logic             strobe
);
  assign pos = {ext, n};
  assign bad = (n == '0) && !ext;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strobe <= 1'b0;
    else        strobe <= step && (cnt == pos) && !bad;
  end
endmodule

// File: rtl/osd_vline_cmp.sv
module osd_vline_cmp
  import osd_vpos_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hsync_in,
  input  logic             vsync_in,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [7:0]       wr_data,
  input  logic [2:0]       rd_addr,
  output logic [7:0]       rd_data,
  output logic [1:0]       blk_start,
  output logic             win_active,
  output logic [2:0]       cfg_bad
);
  localparam int SYNC_STAGES = 2;

  vpos_cfg_t              cfg;
  logic                   hs_rise, vs_rise;
  logic [POS_W-1:0]       line_cnt;
  logic                   line_step;
  logic [NBLK-1:0][POS_W-1:0] start_pos;
  logic [NBLK-1:0]        start_bad;
  logic [POS_W-1:0]       top_pos, bot_pos;
  logic                   top_bad;

  osd_sync_rise #(.STAGES(SYNC_STAGES)) u_hs (
    .clk(clk), .rst_n(rst_n), .async_in(hsync_in), .rise(hs_rise));
  osd_sync_rise #(.STAGES(SYNC_STAGES)) u_vs (
    .clk(clk), .rst_n(rst_n), .async_in(vsync_in), .rise(vs_rise));

  osd_vpos_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .cfg(cfg));

  osd_line_counter #(.POS_W(POS_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .hs_rise(hs_rise), .vs_rise(vs_rise),
    .dbl(cfg.dbl), .cnt(line_cnt), .step(line_step));

  for (genvar b = 0; b < NBLK; b++) begin : g_blk
    osd_start_cmp #(.REG_W(REG_W), .POS_W(POS_W)) u_cmp (
      .clk(clk), .rst_n(rst_n), .cnt(line_cnt), .step(line_step),
      .n(cfg.start[b]), .ext(cfg.ext[b]), .pos(start_pos[b]),
      .bad(start_bad[b]), .strobe(blk_start[b]));
  end

  // window borders borrow the extension bits of block 1 and block 2
  assign top_pos = {cfg.ext[0], cfg.top};
  assign bot_pos = {cfg.ext[1], cfg.bot};
  assign top_bad = (cfg.top == '0) && !cfg.ext[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_active <= 1'b0;
    end else if (vs_rise) begin
      win_active <= 1'b0;
    end else if (line_step) begin
      if (line_cnt == bot_pos)
        win_active <= 1'b0;
      else if ((line_cnt == top_pos) && (top_pos < bot_pos) && !top_bad)
        win_active <= 1'b1;
    end
  end

  assign cfg_bad = {top_bad, start_bad};
endmodule

// File: rtl/osd_vline_cmp_chk.sv
module osd_vline_cmp_chk #(
  parameter int POS_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       blk_start,
  input logic             win_active,
  input logic [2:0]       cfg_bad,
  input logic             vs_rise,
  input logic             line_step,
  input logic [POS_W-1:0] line_cnt,
  input logic [POS_W-1:0] pos0,
  input logic [POS_W-1:0] pos1,
  input logic [POS_W-1:0] top_pos,
  input logic [POS_W-1:0] bot_pos
);
  p_vs_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    vs_rise |=> (line_cnt == '0) && !win_active);

  p_step_by_one_r1: assert property (@(posedge clk) disable iff (!rst_n)
    line_step |-> ((line_cnt - $past(line_cnt)) == POS_W'(1)));

  p_one_clk_b0_r2: assert property (@(posedge clk) disable iff (!rst_n)
    blk_start[0] |=> !blk_start[0]);

  p_one_clk_b1_r2: assert property (@(posedge clk) disable iff (!rst_n)
    blk_start[1] |=> !blk_start[1]);

  p_at_pos_b0_r2: assert property (@(posedge clk) disable iff (!rst_n)
    blk_start[0] |-> line_cnt == pos0);

  p_at_pos_b1_r4: assert property (@(posedge clk) disable iff (!rst_n)
    blk_start[1] |-> line_cnt == pos1);

  p_win_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(win_active) |-> $past(top_pos < bot_pos));

  p_bad_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
    blk_start[0] |-> !$past(cfg_bad[0]));

  p_bad_silent_b1_r7: assert property (@(posedge clk) disable iff (!rst_n)
    blk_start[1] |-> !$past(cfg_bad[1]));
endmodule

bind osd_vline_cmp osd_vline_cmp_chk #(.POS_W(osd_vpos_pkg::POS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .blk_start(blk_start), .win_active(win_active),
  .cfg_bad(cfg_bad), .vs_rise(vs_rise), .line_step(line_step),
  .line_cnt(line_cnt), .pos0(start_pos[0]), .pos1(start_pos[1]),
  .top_pos(top_pos), .bot_pos(bot_pos));

// File: tb/osd_vline_cmp_tb_top.sv
module osd_vline_cmp_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hsync_in = 1'b0, vsync_in = 1'b0, wr_en = 1'b0;
  logic [2:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic [1:0] blk_start;
  logic win_active;
  logic [2:0] cfg_bad;

  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;

  // shadow configuration held by the bench
  int s1, s2, tp, bt;
  bit e1, e2, dbl;
  int tb_unit;

  // scoreboard items: block id * 1000 + expected unit
  int exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  osd_vline_cmp dut_i (
    .clk(clk), .rst_n(rst_n), .hsync_in(hsync_in), .vsync_in(vsync_in),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .blk_start(blk_start), .win_active(win_active),
    .cfg_bad(cfg_bad));

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pop_strobe(int blk);
    checks++;
    if (exp_q.size() == 0) begin
      errors++;
      $display("FAIL R2/R7 unexpected strobe actual=blk%0d@%0d expected=none", blk, tb_unit);
    end else begin
      int item = exp_q.pop_front();
      if (item != blk*1000 + tb_unit) begin
        errors++;
        $display("FAIL R2/R4 strobe actual=%0d expected=%0d", blk*1000 + tb_unit, item);
      end
    end
  endtask

  // monitor: sampled on the falling edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      cycles++;
      if (blk_start[0]) pop_strobe(1);
      if (blk_start[1]) pop_strobe(2);
    end
  end

  task automatic wr(int a, int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = 8'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic setcfg(int a1, int a2, int t, int b, bit x1, bit x2, bit d);
    s1 = a1; s2 = a2; tp = t; bt = b; e1 = x1; e2 = x2; dbl = d;
    wr(0, a1); wr(1, a2); wr(2, t); wr(3, b);
    wr(4, {29'd0, d, x2, x1});
  endtask

  function automatic bit win_exp(int u);
    int tv = tp + (e1 ? 256 : 0);
    int bv = bt + (e2 ? 256 : 0);
    bit tvalid = !(tp == 0 && !e1);
    return tvalid && (tv < bv) && (u >= tv) && (u < bv);
  endfunction

  task automatic field(int pulses, string tag);
    int p1 = s1 + (e1 ? 256 : 0);
    int p2 = s2 + (e2 ? 256 : 0);
    bit v1 = !(s1 == 0 && !e1);
    bit v2 = !(s2 == 0 && !e2);
    @(negedge clk); vsync_in = 1'b1;
    repeat (3) @(negedge clk);
    vsync_in = 1'b0;
    repeat (6) @(negedge clk);
    tb_unit = 0;
    check({tag, " R1 window low after VSYNC"}, win_active, 0);
    for (int i = 1; i <= pulses; i++) begin
      bit stepped = !dbl || (i % 2 == 0);   // R3 unit rate
      if (stepped) begin
        tb_unit++;
        if (v1 && tb_unit == p1) exp_q.push_back(1000 + tb_unit);
        if (v2 && tb_unit == p2) exp_q.push_back(2000 + tb_unit);
      end
      hsync_in = 1'b1;
      repeat (3) @(negedge clk);
      hsync_in = 1'b0;
      repeat (9) @(negedge clk);
      if (stepped) check({tag, " R5 window level"}, win_active, win_exp(tb_unit));
    end
    check({tag, " R2 no strobe missing"}, exp_q.size(), 0);
    exp_q.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 blk_start", blk_start, 0);
    check("R9 win_active", win_active, 0);
    check("R9 cfg_bad", cfg_bad, 3'b111);
    rd_addr = 3'd4; #1 check("R9 ctrl reads 0", rd_data, 0);
    rst_n = 1'b1;

    // R8 readback
    setcfg(5, 9, 3, 7, 1'b0, 1'b0, 1'b0);
    rd_addr = 3'd0; #1 check("R8 start1", rd_data, 5);
    rd_addr = 3'd1; #1 check("R8 start2", rd_data, 9);
    rd_addr = 3'd2; #1 check("R8 top", rd_data, 3);
    rd_addr = 3'd3; #1 check("R8 bottom", rd_data, 7);
    wr(4, 8'hFF);
    rd_addr = 3'd4; #1 check("R8 ctrl unused bits 0", rd_data, 7);
    rd_addr = 3'd6; #1 check("R8 unused address", rd_data, 0);
    wr(4, 0);
    check("R7 no flags when nonzero", cfg_bad, 0);

    // R2 R5: distinct positions, single-HSYNC units
    field(12, "A");
    // R1: repeated field restarts count
    field(12, "A2");

    // R4 same position on both blocks
    setcfg(4, 4, 2, 6, 1'b0, 1'b0, 1'b0);
    field(8, "B");

    // R3 line doubling
    setcfg(3, 5, 2, 5, 1'b0, 1'b0, 1'b1);
    field(14, "C");

    // R2 R5 extension bits: 256, 258, window 257..258
    setcfg(0, 2, 1, 3, 1'b1, 1'b1, 1'b0);
    check("R7 ext clears flags", cfg_bad, 0);
    field(262, "D");

    // R7 zero start, R6 inverted window
    setcfg(0, 3, 6, 4, 1'b0, 1'b0, 1'b0);
    check("R7 start1 flagged", cfg_bad, 3'b001);
    field(10, "E");

    // R7 zero top never opens the window
    setcfg(2, 0, 0, 5, 1'b0, 1'b0, 1'b0);
    check("R7 top and start2 flagged", cfg_bad, 3'b110);
    field(8, "F");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=finished", WATCHDOG);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule